// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm

This block keeps wall-clock time from a one-pulse-per-second tick enable. In calendar mode it carries seconds into minutes, hours, day of month, month and year. It follows the real length of every month and applies the Gregorian leap rule. A separate weekday counter advances at each midnight. In counter mode the calendar stays still, and a free 32-bit count advances once per tick instead. Software reaches everything through one flat register port with a single address bus, a write strobe and a combinational read path.

A small control state machine makes time updates atomic. In ST_RUN the clock advances. Setting the hold bit starts the RUN_TO_HOLD transition, which copies the live time into a staging copy. In ST_HOLD the live time is frozen and writes to time registers land only in the staging copy. Clearing the hold bit starts the HOLD_TO_COMMIT transition. ST_COMMIT loads the whole staging copy in one cycle, then takes COMMIT_TO_RUN unconditionally. The tick that arrives during ST_COMMIT is not counted.

An alarm compares up to four enabled fields (minute, hour, weekday, day of month) against programmed values. It latches a status flag once each time the comparison becomes true, and that flag can drive an interrupt. A signed trim value shortens or lengthens time by one tick per correction period to cancel crystal error.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the block is in calendar mode and running, with interrupt enable off and trim 0. The time reads 00:00:00, weekday 0, day 1, month 1, year 2000. The count reads 0, the alarm status reads 0 and `alarm_irq` is low.
- R2: In calendar mode each tick advances seconds. Seconds wrap from 59 to 0 and carry into minutes, minutes wrap from 59 to 0 and carry into hours, and hours wrap from 23 to 0 and carry into the day.
- R3: Months 4, 6, 9 and 11 end after day 30, and months 1, 3, 5, 7, 8, 10 and 12 end after day 31. The day after the last day is day 1 of the next month.
- R4: February ends after day 29 when the year is divisible by 4 and either not divisible by 100 or divisible by 400, and after day 28 otherwise. Day 31 of month 12 rolls to day 1 of month 1 of the next year.
- R5: The weekday (address 4, values 0 to 6) advances by one at each midnight rollover and wraps from 6 to 0.
- R6: With control bit 1 at 0 (counter mode), each tick increments the 32-bit count, read low half at address 14 and high half at address 15, and the calendar fields do not change.
- R7: Control bit 0 (hold) freezes the time. Writes to addresses 1 to 7, 14 and 15 while held change nothing visible until hold is cleared, and then all of them take effect together. Writes to those addresses while running are ignored.
- R8: The alarm registers are at addresses 8 (minute), 9 (hour), 10 (weekday) and 11 (day). Each holds its value in the low bits and its enable in bit 7. Status bit 0 at address 13 sets once when all enabled fields start to match in calendar mode, and never sets if no field is enabled. Writing 1 to status bit 0 clears it. `alarm_irq` equals status bit 0 ANDed with control bit 2.
- R9: The trim is a 4-bit two's complement value at address 12, and writing it restarts the period. The period is CAL_UNIT×(8−|trim|) ticks, with |trim| capped at 7. At the end of each period a positive trim adds one extra advance and a negative trim drops that tick. A trim of 0 makes no change.

Address 0 is control: bit 0 hold, bit 1 calendar mode, bit 2 interrupt enable. Addresses 1 to 7 hold seconds, minutes, hours, weekday, day, month and year.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second; pulses at least 2 cycles apart |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for reads and writes |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data at `addr` |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The hardest conditions to reach are the rare calendar boundaries: the last second of February in century and non-century years, and year end. Waiting for them tick by tick is far too slow. The bench therefore uses the hold and commit path to load a time one or two seconds before each boundary, then ticks across it. Trim is reached the same way. The bench uses a small CAL_UNIT so that a whole correction period spans a few ticks, and it restarts the period with each trim write so that the extra or dropped advance falls on a known tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HOLD   = 2'd1,
        ST_COMMIT = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic [15:0] year;
        logic [3:0]  mon;
        logic [4:0]  day;
        logic [2:0]  dow;
        logic [4:0]  hour;
        logic [5:0]  min;
        logic [5:0]  sec;
    } cal_t;

    localparam logic [3:0] A_CTRL   = 4'd0;
    localparam logic [3:0] A_SEC    = 4'd1;
    localparam logic [3:0] A_MIN    = 4'd2;
    localparam logic [3:0] A_HOUR   = 4'd3;
    localparam logic [3:0] A_DOW    = 4'd4;
    localparam logic [3:0] A_DAY    = 4'd5;
    localparam logic [3:0] A_MON    = 4'd6;
    localparam logic [3:0] A_YEAR   = 4'd7;
    localparam logic [3:0] A_AMIN   = 4'd8;
    localparam logic [3:0] A_AHOUR  = 4'd9;
    localparam logic [3:0] A_ADOW   = 4'd10;
    localparam logic [3:0] A_ADAY   = 4'd11;
    localparam logic [3:0] A_TRIM   = 4'd12;
    localparam logic [3:0] A_STATUS = 4'd13;
    localparam logic [3:0] A_CNTLO  = 4'd14;
    localparam logic [3:0] A_CNTHI  = 4'd15;

    function automatic logic is_leap(input logic [15:0] y);
        return ((y % 16'd4) == 16'd0 && (y % 16'd100) != 16'd0) || ((y % 16'd400) == 16'd0);
    endfunction

    function automatic logic [4:0] month_days(input logic [3:0] m, input logic [15:0] y);
        logic [4:0] n;
        case (m)
            4'd2:                      n = is_leap(y) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   n = 5'd30;
            default:                   n = 5'd31;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rtc_calib.sv
module rtc_calib #(
    parameter int CAL_UNIT = 256,
    parameter int CAL_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enable,
    input  logic [CAL_W-1:0] trim,
    input  logic             restart,
    output logic             adv
);
    localparam int HALF    = 1 << (CAL_W - 1);
    localparam int PER_MAX = CAL_UNIT * HALF;
    localparam int PW      = $clog2(PER_MAX + 1);
    localparam int PW1     = PW + 1;
    localparam logic [CAL_W-1:0] MAG_MAX = CAL_W'(HALF - 1);
    localparam logic [CAL_W-1:0] HALF_V  = CAL_W'(HALF);

    logic [PW-1:0]    pcnt_q;
    logic             pend_q;
    logic [CAL_W-1:0] mag, mag_c, steps;
    logic [PW1-1:0]   period;
    logic             neg, pos, period_end, raw;

    always_comb begin
        neg   = trim[CAL_W-1];
        pos   = !neg && (trim != '0);
        mag   = neg ? (~trim + {{(CAL_W-1){1'b0}}, 1'b1}) : trim;
        mag_c = (mag > MAG_MAX) ? MAG_MAX : mag;
        steps = HALF_V - mag_c;
        period = PW1'(CAL_UNIT) * PW1'(steps);
        period_end = (PW1'(pcnt_q) + PW1'(1)) >= period;
        raw = tick && enable;
        adv = (raw && !(period_end && neg)) || (pend_q && enable);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            pend_q <= 1'b0;
        end else if (restart) begin
            pcnt_q <= '0;
            pend_q <= 1'b0;
        end else begin
            pend_q <= raw && period_end && pos;
            if (raw) begin
                pcnt_q <= period_end ? '0 : pcnt_q + PW'(1);
            end
        end
    end

    // an advance is only ever the tick itself or the extra one right after it
    assert_adv_near_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (tick || $past(tick)));

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
    parameter int YEAR0 = 2000,
    parameter int DW    = 16,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             run,
    input  logic             cal_mode,
    input  logic             capture,
    input  logic             commit,
    input  logic             sh_we,
    input  logic [3:0]       addr,
    input  logic [DW-1:0]    wdata,
    output rtc_pkg::cal_t    t_o,
    output logic [CNT_W-1:0] cnt_o
);
    import rtc_pkg::*;

    cal_t             t_q, t_s, t_nxt;
    logic [CNT_W-1:0] cnt_q, cnt_s;
    logic             midnight;

    localparam cal_t T_RST = '{year: 16'(YEAR0), mon: 4'd1, day: 5'd1,
                               dow: 3'd0, hour: 5'd0, min: 6'd0, sec: 6'd0};

    always_comb begin
        t_nxt    = t_q;
        midnight = (t_q.sec == 6'd59) && (t_q.min == 6'd59) && (t_q.hour == 5'd23);
        if (t_q.sec != 6'd59) begin
            t_nxt.sec = t_q.sec + 6'd1;
        end else begin
            t_nxt.sec = 6'd0;
            if (t_q.min != 6'd59) begin
                t_nxt.min = t_q.min + 6'd1;
            end else begin
                t_nxt.min = 6'd0;
                if (t_q.hour != 5'd23) begin
                    t_nxt.hour = t_q.hour + 5'd1;
                end else begin
                    t_nxt.hour = 5'd0;
                    t_nxt.dow  = (t_q.dow >= 3'd6) ? 3'd0 : t_q.dow + 3'd1;
                    if (t_q.day >= month_days(t_q.mon, t_q.year)) begin
                        t_nxt.day = 5'd1;
                        if (t_q.mon >= 4'd12) begin
                            t_nxt.mon  = 4'd1;
                            t_nxt.year = t_q.year + 16'd1;
                        end else begin
                            t_nxt.mon = t_q.mon + 4'd1;
                        end
                    end else begin
                        t_nxt.day = t_q.day + 5'd1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q   <= T_RST;
            cnt_q <= '0;
        end else if (commit) begin
            t_q   <= t_s;
            cnt_q <= cnt_s;
        end else if (run && adv) begin
            if (cal_mode) t_q   <= t_nxt;
            else          cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_s   <= T_RST;
            cnt_s <= '0;
        end else if (capture) begin
            t_s   <= t_q;
            cnt_s <= cnt_q;
        end else if (sh_we) begin
            case (addr)
                A_SEC:   t_s.sec  <= wdata[5:0];
                A_MIN:   t_s.min  <= wdata[5:0];
                A_HOUR:  t_s.hour <= wdata[4:0];
                A_DOW:   t_s.dow  <= wdata[2:0];
                A_DAY:   t_s.day  <= wdata[4:0];
                A_MON:   t_s.mon  <= wdata[3:0];
                A_YEAR:  t_s.year <= wdata[15:0];
                A_CNTLO: cnt_s[DW-1:0]       <= wdata;
                A_CNTHI: cnt_s[CNT_W-1:DW]   <= wdata[CNT_W-DW-1:0];
                default: ;
            endcase
        end
    end

    assign t_o   = t_q;
    assign cnt_o = cnt_q;

    assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && adv && cal_mode && t_q.sec == 6'd59) |=> (t_q.sec == 6'd0));

    assert_day_moves_at_midnight_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && adv && cal_mode && midnight) |=> (t_q.hour == 5'd0 && t_q.day != $past(t_q.day)));

    assert_dow_moves_at_midnight_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && adv && cal_mode && midnight) |=> (t_q.dow != $past(t_q.dow)));

    assert_count_still_in_calendar_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_mode && !commit) |=> $stable(cnt_q));

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  rtc_pkg::cal_t t,
    input  logic          cal_mode,
    input  logic          irq_en,
    input  logic          we,
    input  logic [3:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [7:0]    a_min,
    output logic [7:0]    a_hour,
    output logic [7:0]    a_dow,
    output logic [7:0]    a_day,
    output logic          flag,
    output logic          irq
);
    import rtc_pkg::*;

    logic [7:0] amin_q, ahour_q, adow_q, aday_q;
    logic       flag_q, prev_q, match, any_en, fire, clr;

    always_comb begin
        any_en = amin_q[7] | ahour_q[7] | adow_q[7] | aday_q[7];
        match  = any_en
               && (!amin_q[7]  || amin_q[5:0]  == t.min)
               && (!ahour_q[7] || ahour_q[4:0] == t.hour)
               && (!adow_q[7]  || adow_q[2:0]  == t.dow)
               && (!aday_q[7]  || aday_q[4:0]  == t.day);
        fire   = match && !prev_q && cal_mode;
        clr    = we && (addr == A_STATUS) && wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            amin_q  <= '0;
            ahour_q <= '0;
            adow_q  <= '0;
            aday_q  <= '0;
        end else if (we) begin
            case (addr)
                A_AMIN:  amin_q  <= wdata[7:0];
                A_AHOUR: ahour_q <= wdata[7:0];
                A_ADOW:  adow_q  <= wdata[7:0];
                A_ADAY:  aday_q  <= wdata[7:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= match;
            if (fire)     flag_q <= 1'b1;
            else if (clr) flag_q <= 1'b0;
        end
    end

    assign a_min  = amin_q;
    assign a_hour = ahour_q;
    assign a_dow  = adow_q;
    assign a_day  = aday_q;
    assign flag   = flag_q;
    assign irq    = flag_q & irq_en;

    assert_flag_needs_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(match && cal_mode));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
    parameter int YEAR0    = 2000,
    parameter int CAL_UNIT = 256,
    parameter int CAL_W    = 4,
    parameter int DW       = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_1hz,
    input  logic          wr_en,
    input  logic [3:0]    addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          alarm_irq
);
    import rtc_pkg::*;

    localparam int CNT_W = 2 * DW;

    ctl_state_e       state_q, state_d;
    logic             hold_q, calm_q, ie_q;
    logic [CAL_W-1:0] trim_q;
    logic             run, capture, commit, sh_we, adv, trim_wr;
    cal_t             t;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       a_min, a_hour, a_dow, a_day;
    logic             flag;

    // control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            calm_q <= 1'b1;
            ie_q   <= 1'b0;
            trim_q <= '0;
        end else if (wr_en) begin
            if (addr == A_CTRL) begin
                hold_q <= wr_data[0];
                calm_q <= wr_data[1];
                ie_q   <= wr_data[2];
            end
            if (addr == A_TRIM) trim_q <= wr_data[CAL_W-1:0];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        run     = 1'b0;
        capture = 1'b0;
        commit  = 1'b0;
        sh_we   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                run     = !hold_q;
                capture = hold_q;
                if (hold_q) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                sh_we = wr_en;
                if (!hold_q) state_d = ST_COMMIT;
            end
            ST_COMMIT: begin
                commit  = 1'b1;
                state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    assign trim_wr = wr_en && (addr == A_TRIM);

    rtc_calib #(.CAL_UNIT(CAL_UNIT), .CAL_W(CAL_W)) calib_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .enable(run),
        .trim(trim_q), .restart(trim_wr), .adv(adv)
    );

    rtc_time_core #(.YEAR0(YEAR0), .DW(DW), .CNT_W(CNT_W)) core_i (
        .clk(clk), .rst_n(rst_n), .adv(adv), .run(run), .cal_mode(calm_q),
        .capture(capture), .commit(commit), .sh_we(sh_we), .addr(addr),
        .wdata(wr_data), .t_o(t), .cnt_o(cnt)
    );

    rtc_alarm #(.DW(DW)) alarm_i (
        .clk(clk), .rst_n(rst_n), .t(t), .cal_mode(calm_q), .irq_en(ie_q),
        .we(wr_en), .addr(addr), .wdata(wr_data),
        .a_min(a_min), .a_hour(a_hour), .a_dow(a_dow), .a_day(a_day),
        .flag(flag), .irq(alarm_irq)
    );

    always_comb begin
        rd_data = '0;
        case (addr)
            A_CTRL:   rd_data = DW'({ie_q, calm_q, hold_q});
            A_SEC:    rd_data = DW'(t.sec);
            A_MIN:    rd_data = DW'(t.min);
            A_HOUR:   rd_data = DW'(t.hour);
            A_DOW:    rd_data = DW'(t.dow);
            A_DAY:    rd_data = DW'(t.day);
            A_MON:    rd_data = DW'(t.mon);
            A_YEAR:   rd_data = t.year;
            A_AMIN:   rd_data = DW'(a_min);
            A_AHOUR:  rd_data = DW'(a_hour);
            A_ADOW:   rd_data = DW'(a_dow);
            A_ADAY:   rd_data = DW'(a_day);
            A_TRIM:   rd_data = DW'(trim_q);
            A_STATUS: rd_data = DW'(flag);
            A_CNTLO:  rd_data = cnt[DW-1:0];
            A_CNTHI:  rd_data = cnt[CNT_W-1:DW];
            default:  rd_data = '0;
        endcase
    end

    assert_frozen_in_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> ($stable(t) && $stable(cnt)));

    assert_commit_returns_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |=> (state_q == ST_RUN));

endmodule

// File: tb/rtc_calendar_tb_top.sv
module rtc_calendar_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] rd_data;
    logic        alarm_irq;

    int errors = 0;
    int checks = 0;
    logic [15:0] ctrl_base = 16'h0002;

    always #2 clk = ~clk;

    rtc_calendar #(.YEAR0(2000), .CAL_UNIT(4), .CAL_W(4), .DW(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .alarm_irq(alarm_irq)
    );

    task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic rdchk(input string req, input logic [3:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        check(req, $sformatf("addr %0d", a), {16'd0, v}, {16'd0, exp});
    endtask

    task automatic tick1;
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        idle(2);
    endtask

    task automatic set_time(input int y, input int mo, input int d, input int dw,
                            input int h, input int mi, input int s);
        wr(4'd0, ctrl_base | 16'h1);
        idle(2);
        wr(4'd1, 16'(s));  wr(4'd2, 16'(mi)); wr(4'd3, 16'(h));
        wr(4'd4, 16'(dw)); wr(4'd5, 16'(d));  wr(4'd6, 16'(mo));
        wr(4'd7, 16'(y));
        wr(4'd0, ctrl_base);
        idle(3);
    endtask

    task automatic test_reset;
        rdchk("R1", 4'd1, 16'd0);  rdchk("R1", 4'd2, 16'd0);
        rdchk("R1", 4'd3, 16'd0);  rdchk("R1", 4'd4, 16'd0);
        rdchk("R1", 4'd5, 16'd1);  rdchk("R1", 4'd6, 16'd1);
        rdchk("R1", 4'd7, 16'd2000); rdchk("R1", 4'd0, 16'd2);
        rdchk("R1", 4'd14, 16'd0); rdchk("R1", 4'd13, 16'd0);
        check("R1", "irq", {31'd0, alarm_irq}, 32'd0);
    endtask

    task automatic test_carry;
        set_time(2023, 4, 30, 6, 23, 59, 58);
        tick1;
        rdchk("R2", 4'd1, 16'd59); rdchk("R2", 4'd2, 16'd59);
        tick1;
        rdchk("R2", 4'd1, 16'd0); rdchk("R2", 4'd2, 16'd0); rdchk("R2", 4'd3, 16'd0);
        rdchk("R3", 4'd5, 16'd1); rdchk("R3", 4'd6, 16'd5);
        rdchk("R5", 4'd4, 16'd0);
        set_time(2023, 1, 31, 2, 23, 59, 59);
        tick1;
        rdchk("R3", 4'd5, 16'd1); rdchk("R3", 4'd6, 16'd2); rdchk("R5", 4'd4, 16'd3);
        set_time(2023, 6, 29, 4, 23, 59, 59);
        tick1;
        rdchk("R3", 4'd5, 16'd30); rdchk("R3", 4'd6, 16'd6);
    endtask

    task automatic feb_end(input int y, input int exp_day, input int exp_mon);
        set_time(y, 2, 28, 1, 23, 59, 59);
        tick1;
        rdchk("R4", 4'd5, 16'(exp_day));
        rdchk("R4", 4'd6, 16'(exp_mon));
    endtask

    task automatic test_leap;
        feb_end(2024, 29, 2);
        feb_end(2023, 1, 3);
        feb_end(2100, 1, 3);
        feb_end(2000, 29, 2);
        set_time(2023, 12, 31, 6, 23, 59, 59);
        tick1;
        rdchk("R4", 4'd7, 16'd2024); rdchk("R4", 4'd6, 16'd1); rdchk("R4", 4'd5, 16'd1);
    endtask

    task automatic test_hold;
        set_time(2023, 5, 1, 1, 8, 0, 20);
        wr(4'd1, 16'd30);
        rdchk("R7", 4'd1, 16'd20);
        wr(4'd0, ctrl_base | 16'h1);
        idle(2);
        wr(4'd1, 16'd10); wr(4'd2, 16'd45);
        tick1;
        rdchk("R7", 4'd1, 16'd20); rdchk("R7", 4'd2, 16'd0);
        wr(4'd0, ctrl_base);
        idle(3);
        rdchk("R7", 4'd1, 16'd10); rdchk("R7", 4'd2, 16'd45);
    endtask

    task automatic test_counter;
        logic [15:0] s0;
        rd(4'd1, s0);
        ctrl_base = 16'h0000;
        wr(4'd0, 16'h1);
        idle(2);
        wr(4'd14, 16'hFFFF); wr(4'd15, 16'h0000);
        wr(4'd0, 16'h0);
        idle(3);
        tick1; tick1;
        rdchk("R6", 4'd14, 16'd1); rdchk("R6", 4'd15, 16'd1);
        rdchk("R6", 4'd1, s0);
        ctrl_base = 16'h0002;
        wr(4'd0, ctrl_base);
        idle(2);
    endtask

    task automatic test_alarm;
        ctrl_base = 16'h0006;
        wr(4'd8, 16'h0080 | 16'd30); wr(4'd9, 16'h0080 | 16'd10);
        set_time(2023, 5, 1, 1, 10, 29, 59);
        rdchk("R8", 4'd13, 16'd0);
        tick1;
        rdchk("R8", 4'd13, 16'd1);
        check("R8", "irq", {31'd0, alarm_irq}, 32'd1);
        wr(4'd13, 16'd1);
        rdchk("R8", 4'd13, 16'd0);
        tick1;
        rdchk("R8", 4'd13, 16'd0);
        check("R8", "irq after clear", {31'd0, alarm_irq}, 32'd0);
        wr(4'd8, 16'd30); wr(4'd9, 16'd10);
        set_time(2023, 5, 1, 1, 10, 29, 59);
        tick1;
        rdchk("R8", 4'd13, 16'd0);
        ctrl_base = 16'h0002;
        wr(4'd0, ctrl_base);
    endtask

    task automatic test_trim;
        set_time(2023, 5, 1, 1, 0, 0, 0);
        wr(4'd12, 16'd7);
        for (int i = 0; i < 4; i++) tick1;
        rdchk("R9", 4'd1, 16'd5);
        wr(4'd12, 16'd9);
        for (int i = 0; i < 4; i++) tick1;
        rdchk("R9", 4'd1, 16'd8);
        wr(4'd12, 16'd0);
        for (int i = 0; i < 4; i++) tick1;
        rdchk("R9", 4'd1, 16'd12);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        test_reset;
        test_carry;
        test_leap;
        test_hold;
        test_counter;
        test_alarm;
        test_trim;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule